// File: doc/BRIEF.md
# Pixel Format Unpacker

This block turns a stream of 32-bit frame-buffer words into a stream of 24-bit RGB pixels, one pixel per handshake. It takes one word, emits every pixel packed in that word, then frees itself for the next word. A 3-bit depth code selects the format. Depths of 8 bits or fewer are palette modes: each pixel becomes an index, an external lookup returns the colour, and that colour is passed straight to the output. The wider depths are direct colour: the block splits out the channels and left-shifts each one to 8 bits.

Control inputs set three more things. They choose whether red sits in the low or the high field of a direct pixel. They choose the order in which pixels are taken from a word. In the base variant, a 2-bit external selector changes how the plain 16-bit depth is read. A combinational side output gives the number of source bytes in one line for a given column count, so that a fetch engine can size its line reads. Memory fetch and panel timing belong to other blocks.

Top module: `pix_unpack`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A word is taken on a cycle where in_valid and in_ready are both 1. While the block holds a word, in_ready is 0. in_ready returns to 1 on the cycle after the last pixel of that word is taken with out_valid and out_ready both 1.
- R3: Depth code to bits per pixel: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 4, 6 and 7 give 16, and 5 gives 32. Each word yields 32/bpp pixels.
- R4: Pixel order for pixel number k (from 0). By default pixel k is word bits [k*bpp +: bpp]. With big_byte=1 it is bits [32-(k+1)*bpp +: bpp]. With big_byte=0, big_pix=1 and bpp below 8, bytes stay in little-endian order but pixels inside each byte are taken from the top of the byte down. At 8 bpp and wider, big_pix alone has no effect.
- R5: In palette modes (codes 0 to 3), pal_idx is the pixel field zero-extended to 8 bits, and out_rgb equals pal_rgb. In direct modes, pal_idx is 0.
- R6: Direct field layouts, each field left-shifted to 8 bits with zero fill. 5551 uses fields [4:0], [9:5] and [14:10], and bit 15 is ignored. 565 uses [4:0], [10:5] and [15:11]. 444 (code 7) uses [3:0], [7:4] and [11:8]. 32 bpp (code 5) uses [7:0], [15:8] and [23:16], and bits 31:24 are ignored. The middle field is always green.
- R7: out_rgb is {red, green, blue}, with red in [23:16]. With bgr=1, red is the low field and blue the high field. With bgr=0, the two are swapped.
- R8: Base variant (EXTENDED=0), code 4. mux_sel=1 gives 5551. mux_sel=3 gives 565 with red in the low field whatever bgr is. mux_sel=0 or 2 gives 565 and follows bgr.
- R9: Extended variant (EXTENDED=1): code 4 is always 5551, whatever mux_sel is. In both variants, code 6 is 565 and code 7 is 444.
- R10: While out_valid=1 and out_ready=0, out_valid stays 1 and out_rgb holds its value on the next cycle.
- R11: line_bytes follows the live mode input. It is cols/8, cols/4, cols/2 or cols for codes 0 to 3 (bits shifted out are dropped), cols*2 for codes 4, 6 and 7, and cols*4 for code 5.
- R12: mode, bgr, big_byte, big_pix and mux_sel are sampled when a word is taken. Changes to them while that word is held have no effect on its pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Depth code |
| bgr | input | 1 | Red in low field when 1 |
| big_byte | input | 1 | Whole-word big-endian pixel order |
| big_pix | input | 1 | Big-endian pixel order inside bytes |
| mux_sel | input | 2 | External 16-bit reinterpretation selector |
| in_valid | input | 1 | Word available |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Frame-buffer word |
| pal_idx | output | 8 | Palette lookup index |
| pal_rgb | input | 24 | Palette lookup result, combinational on pal_idx |
| out_valid | output | 1 | Pixel available |
| out_ready | input | 1 | Consumer takes pixel |
| out_rgb | output | 24 | Pixel colour {R,G,B} |
| cols | input | 12 | Column count for the line size |
| line_bytes | output | 14 | Source bytes per line |

## Verification
The hold-stability property assumes that pal_rgb is a pure function of pal_idx, with no state in the lookup. The bench keeps to this by driving pal_rgb from a fixed combinational map. The other properties assume only that the inputs are known after reset. The bench drives every input from reset onwards and changes it only on falling edges. It also scrambles the control inputs while a word is held, to test that they are sampled at acceptance.

// File: rtl/pix_unpack_pkg.sv
// Shared types and helpers for the pixel unpacker.
// Assumes a 32-bit source word; depth codes are 3 bits.
package pix_unpack_pkg;

    typedef enum logic [2:0] {
        FMT_PAL  = 3'd0,
        FMT_5551 = 3'd1,
        FMT_565  = 3'd2,
        FMT_444  = 3'd3,
        FMT_888  = 3'd4
    } pix_fmt_e;

    typedef struct packed {
        logic [2:0] mode;
        logic       bgr;
        logic       be_byte;
        logic       be_pix;
        logic [1:0] mux;
    } pix_cfg_t;

    // log2 of bits per pixel for a depth code
    function automatic logic [2:0] depth_log(input logic [2:0] code);
        case (code)
            3'd0, 3'd1, 3'd2, 3'd3: depth_log = code;
            3'd5:                   depth_log = 3'd5;
            default:                depth_log = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pix_cfg_decode.sv
// Decodes a latched configuration into pixel size, colour format,
// red placement and the XOR mask applied to pixel bit offsets.
// Assumes cfg is stable for as long as a word is held.
module pix_cfg_decode
    import pix_unpack_pkg::*;
#(
    parameter bit EXTENDED = 1'b0
) (
    input  pix_cfg_t   cfg,
    output logic [2:0] lg,
    output pix_fmt_e   fmt,
    output logic       red_low,
    output logic [4:0] off_mask
);
    logic [5:0] bpp_m1;

    // pixel size and offset mask for the selected ordering
    always_comb begin
        lg     = depth_log(cfg.mode);
        bpp_m1 = (6'd1 << lg) - 6'd1;
        if (cfg.be_byte)
            off_mask = 5'd31 & ~bpp_m1[4:0];
        else if (cfg.be_pix && lg < 3'd3)
            off_mask = 5'd7 & ~bpp_m1[4:0];
        else
            off_mask = 5'd0;
    end

    generate
        if (EXTENDED) begin : g_ext
            // extended variant: code 4 is fixed 5551, selector unused
            always_comb begin
                red_low = cfg.bgr;
                case (cfg.mode)
                    3'd4:    fmt = FMT_5551;
                    3'd5:    fmt = FMT_888;
                    3'd6:    fmt = FMT_565;
                    3'd7:    fmt = FMT_444;
                    default: fmt = FMT_PAL;
                endcase
            end
        end else begin : g_base
            // base variant: external selector reinterprets code 4
            always_comb begin
                red_low = cfg.bgr;
                case (cfg.mode)
                    3'd4: begin
                        if (cfg.mux == 2'd1) begin
                            fmt = FMT_5551;
                        end else begin
                            fmt = FMT_565;
                            if (cfg.mux == 2'd3) red_low = 1'b1;
                        end
                    end
                    3'd5:    fmt = FMT_888;
                    3'd6:    fmt = FMT_565;
                    3'd7:    fmt = FMT_444;
                    default: fmt = FMT_PAL;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/pix_select.sv
// Picks the field of pixel k out of a held word with a barrel shift.
// Offset = (k << lg) XOR mask, which covers all three orderings because
// every pixel field is aligned to its own size.
module pix_select #(
    parameter int WORD_W = 32,
    parameter int FIELD_W = 24,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0]  word,
    input  logic [IDX_W-1:0]   k,
    input  logic [2:0]         lg,
    input  logic [IDX_W-1:0]   off_mask,
    output logic [IDX_W-1:0]   off,
    output logic [FIELD_W-1:0] field
);
    logic [WORD_W-1:0] shifted;

    // bit offset and right-aligned field of the current pixel
    always_comb begin
        off     = (k << lg) ^ off_mask;
        shifted = word >> off;
        field   = shifted[FIELD_W-1:0];
    end

endmodule

// File: rtl/pix_colour.sv
// Turns a right-aligned pixel field into a palette index or a widened
// RGB value. Assumes pal_rgb is a combinational function of pal_idx.
module pix_colour
    import pix_unpack_pkg::*;
(
    input  logic [23:0] field,
    input  logic [2:0]  lg,
    input  pix_fmt_e    fmt,
    input  logic        red_low,
    input  logic [23:0] pal_rgb,
    output logic [7:0]  pal_idx,
    output logic [23:0] rgb
);
    logic [7:0]  lo, mid, hi;
    logic [15:0] idx_mask;

    // palette index: field masked to the pixel size
    always_comb begin
        idx_mask = (16'd1 << (5'd1 << lg)) - 16'd1;
        pal_idx  = (fmt == FMT_PAL) ? (field[7:0] & idx_mask[7:0]) : 8'd0;
    end

    // channel split, widening and red/blue placement
    always_comb begin
        case (fmt)
            FMT_5551: begin
                lo = {field[4:0], 3'b0}; mid = {field[9:5], 3'b0}; hi = {field[14:10], 3'b0};
            end
            FMT_565: begin
                lo = {field[4:0], 3'b0}; mid = {field[10:5], 2'b0}; hi = {field[15:11], 3'b0};
            end
            FMT_444: begin
                lo = {field[3:0], 4'b0}; mid = {field[7:4], 4'b0}; hi = {field[11:8], 4'b0};
            end
            default: begin
                lo = field[7:0]; mid = field[15:8]; hi = field[23:16];
            end
        endcase
        if (fmt == FMT_PAL)
            rgb = pal_rgb;
        else if (red_low)
            rgb = {lo, mid, hi};
        else
            rgb = {hi, mid, lo};
    end

endmodule

// File: rtl/pix_unpack.sv
// Pixel format unpacker top. Holds one word with its configuration,
// steps a pixel counter on each output handshake and frees the word
// after its last pixel. Line size is computed from the live inputs.
module pix_unpack
    import pix_unpack_pkg::*;
#(
    parameter bit EXTENDED = 1'b0,
    parameter int COL_W = 12,
    localparam int WORD_W = 32,
    localparam int IDX_W = $clog2(WORD_W),
    localparam int LB_W = COL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              bgr,
    input  logic              big_byte,
    input  logic              big_pix,
    input  logic [1:0]        mux_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic [7:0]        pal_idx,
    input  logic [23:0]       pal_rgb,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [23:0]       out_rgb,
    input  logic [COL_W-1:0]  cols,
    output logic [LB_W-1:0]   line_bytes
);
    logic              full;
    logic [WORD_W-1:0] word_q;
    pix_cfg_t          cfg_q;
    logic [IDX_W-1:0]  k_q;
    logic [2:0]        lg;
    pix_fmt_e          fmt;
    logic              red_low;
    logic [IDX_W-1:0]  off_mask;
    logic [IDX_W-1:0]  off;
    logic [23:0]       field;
    logic [IDX_W-1:0]  k_last;
    logic              accept, fire;

    assign in_ready  = ~full;
    assign out_valid = full;
    assign accept    = in_valid & ~full;
    assign fire      = full & out_ready;
    assign k_last    = IDX_W'((WORD_W - 1) >> lg);

    // word holding register, config latch and pixel counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            word_q <= '0;
            cfg_q  <= '0;
            k_q    <= '0;
        end else if (accept) begin
            full   <= 1'b1;
            word_q <= in_word;
            cfg_q  <= '{mode: mode, bgr: bgr, be_byte: big_byte, be_pix: big_pix, mux: mux_sel};
            k_q    <= '0;
        end else if (fire) begin
            if (k_q == k_last) full <= 1'b0;
            else               k_q  <= k_q + 1'b1;
        end
    end

    pix_cfg_decode #(.EXTENDED(EXTENDED)) u_dec (
        .cfg(cfg_q), .lg(lg), .fmt(fmt), .red_low(red_low), .off_mask(off_mask)
    );

    pix_select #(.WORD_W(WORD_W), .FIELD_W(24)) u_sel (
        .word(word_q), .k(k_q), .lg(lg), .off_mask(off_mask), .off(off), .field(field)
    );

    pix_colour u_col (
        .field(field), .lg(lg), .fmt(fmt), .red_low(red_low),
        .pal_rgb(pal_rgb), .pal_idx(pal_idx), .rgb(out_rgb)
    );

    // source bytes per line from the live depth code
    always_comb begin
        case (mode)
            3'd0:    line_bytes = LB_W'(cols >> 3);
            3'd1:    line_bytes = LB_W'(cols >> 2);
            3'd2:    line_bytes = LB_W'(cols >> 1);
            3'd3:    line_bytes = LB_W'(cols);
            3'd5:    line_bytes = {cols, 2'b00};
            default: line_bytes = LB_W'({cols, 1'b0});
        endcase
    end

    // R10: a stalled pixel stays presented and unchanged
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_rgb));

    // R2: a taken word is presented on the next cycle
    a_r2_accept_presents: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && !in_ready);

    // R2: the held word is released only after its last pixel was taken
    a_r2_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_ready) && $past(k_q) == $past(k_last));

    // R4: the pixel offset is aligned to the pixel size
    a_r4_offset_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> ((off >> lg) << lg) == off);

    // R12: the held configuration does not move while a word is held
    a_r12_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        full && $past(full) |-> $stable(cfg_q));

endmodule

// File: tb/pix_unpack_tb.sv
module pix_unpack_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = '0;
    logic        bgr = 1'b0, big_byte = 1'b0, big_pix = 1'b0;
    logic [1:0]  mux_sel = '0;
    logic        in_valid = 1'b0, out_ready = 1'b0;
    logic [31:0] in_word = '0;
    logic [11:0] cols = '0;
    logic        in_ready, out_valid, in_ready_x, out_valid_x;
    logic [7:0]  pal_idx, pal_idx_x;
    logic [23:0] pal_rgb, pal_rgb_x, out_rgb, out_rgb_x;
    logic [13:0] line_bytes, line_bytes_x;
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    function automatic logic [23:0] pal_fn(input logic [7:0] i);
        return {i, i ^ 8'hA5, ~i};
    endfunction

    assign pal_rgb   = pal_fn(pal_idx);
    assign pal_rgb_x = pal_fn(pal_idx_x);

    pix_unpack #(.EXTENDED(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .bgr(bgr), .big_byte(big_byte),
        .big_pix(big_pix), .mux_sel(mux_sel), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .pal_idx(pal_idx), .pal_rgb(pal_rgb), .out_valid(out_valid),
        .out_ready(out_ready), .out_rgb(out_rgb), .cols(cols), .line_bytes(line_bytes));

    pix_unpack #(.EXTENDED(1'b1)) u_dut_ext (
        .clk(clk), .rst_n(rst_n), .mode(mode), .bgr(bgr), .big_byte(big_byte),
        .big_pix(big_pix), .mux_sel(mux_sel), .in_valid(in_valid), .in_ready(in_ready_x),
        .in_word(in_word), .pal_idx(pal_idx_x), .pal_rgb(pal_rgb_x), .out_valid(out_valid_x),
        .out_ready(out_ready), .out_rgb(out_rgb_x), .cols(cols), .line_bytes(line_bytes_x));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int bpp_of(input logic [2:0] m);
        case (m)
            3'd0: return 1; 3'd1: return 2; 3'd2: return 4; 3'd3: return 8;
            3'd5: return 32; default: return 16;
        endcase
    endfunction

    // expected pixel from the requirement text
    function automatic logic [23:0] exp_pix(input logic [31:0] w, input int k, input logic [2:0] m,
        input bit b, input bit bb, input bit bp, input logic [1:0] mx, input bit ext);
        int bpp = bpp_of(m);
        int pos, per;
        logic [31:0] f;
        logic [7:0] lo, mid, hi;
        bit rl = b;
        int fm; // 1=5551 2=565 3=444 4=888
        if (bb) pos = 32 - (k + 1) * bpp;
        else if (bp && bpp < 8) begin
            per = 8 / bpp;
            pos = (k / per) * 8 + 8 - ((k % per) + 1) * bpp;
        end else pos = k * bpp;
        f = w >> pos;
        if (m < 3'd4) return pal_fn(8'(f & ((32'd1 << bpp) - 1)));
        case (m)
            3'd5: fm = 4;
            3'd6: fm = 2;
            3'd7: fm = 3;
            default: begin
                if (ext || mx == 2'd1) fm = 1;
                else begin fm = 2; if (mx == 2'd3) rl = 1; end
            end
        endcase
        case (fm)
            1: begin lo = {f[4:0],3'b0}; mid = {f[9:5],3'b0}; hi = {f[14:10],3'b0}; end
            2: begin lo = {f[4:0],3'b0}; mid = {f[10:5],2'b0}; hi = {f[15:11],3'b0}; end
            3: begin lo = {f[3:0],4'b0}; mid = {f[7:4],4'b0}; hi = {f[11:8],4'b0}; end
            default: begin lo = f[7:0]; mid = f[15:8]; hi = f[23:16]; end
        endcase
        return rl ? {lo, mid, hi} : {hi, mid, lo};
    endfunction

    // send one word at a falling edge and drain all its pixels
    task automatic run_word(input logic [31:0] w, input logic [2:0] m, input bit b,
        input bit bb, input bit bp, input logic [1:0] mx, input bit scramble);
        int n = 32 / bpp_of(m);
        int p = 0;
        logic [23:0] e, ex;
        mode = m; bgr = b; big_byte = bb; big_pix = bp; mux_sel = mx;
        in_word = w; in_valid = 1'b1;
        chk(in_ready && in_ready_x, "R2 ready before accept", {30'd0, in_ready, in_ready_x}, 32'd3);
        @(negedge clk);
        in_valid = 1'b0;
        if (scramble) begin // R12: changes after accept must not matter
            mode = 3'($urandom); bgr = ~bgr; big_byte = ~big_byte; big_pix = ~big_pix;
            mux_sel = 2'($urandom);
        end
        while (p < n) begin
            out_ready = ($urandom % 10) < 7;
            e  = exp_pix(w, p, m, b, bb, bp, mx, 1'b0);
            ex = exp_pix(w, p, m, b, bb, bp, mx, 1'b1);
            chk(out_valid && !in_ready, "R2 held word presents", {30'd0, out_valid, in_ready}, 32'd2);
            chk(out_rgb == e, $sformatf("R4/R6/R7/R8/R10/R12 base mode=%0d k=%0d", m, p), {8'd0, out_rgb}, {8'd0, e});
            chk(out_rgb_x == ex, $sformatf("R9 ext mode=%0d k=%0d", m, p), {8'd0, out_rgb_x}, {8'd0, ex});
            if (m < 3'd4)
                chk(pal_rgb == out_rgb, "R5 palette passthrough", {8'd0, out_rgb}, {8'd0, pal_rgb});
            else
                chk(pal_idx == 8'd0, "R5 index zero in direct mode", {24'd0, pal_idx}, 32'd0);
            if (out_ready) p++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(!out_valid && in_ready, $sformatf("R3 released after %0d pixels", n),
            {30'd0, out_valid, in_ready}, 32'd1);
    endtask

    task automatic chk_lb(input logic [2:0] m, input logic [11:0] c, input int exp);
        mode = m; cols = c; #1;
        chk(line_bytes == 14'(exp) && line_bytes_x == 14'(exp), $sformatf("R11 mode=%0d", m),
            {18'd0, line_bytes}, exp);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_valid_x, "R1 reset valid", {31'd0, out_valid}, 32'd0);
        chk(in_ready && in_ready_x, "R1 reset ready", {31'd0, in_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 line sizes
        chk_lb(3'd0, 12'd1000, 125);  chk_lb(3'd1, 12'd1000, 250);
        chk_lb(3'd2, 12'd1000, 500);  chk_lb(3'd3, 12'd1000, 1000);
        chk_lb(3'd4, 12'd1000, 2000); chk_lb(3'd5, 12'd1000, 4000);
        chk_lb(3'd6, 12'd1000, 2000); chk_lb(3'd7, 12'd1000, 2000);
        chk_lb(3'd5, 12'd4095, 16380); chk_lb(3'd0, 12'd4095, 511);
        @(negedge clk);
        // directed: every depth under every ordering, both colour orders
        for (int m = 0; m < 8; m++)
            for (int o = 0; o < 3; o++)
                for (int b = 0; b < 2; b++)
                    run_word(32'h8E3C_51A7, 3'(m), b[0], o == 1, o == 2, 2'd0, 1'b0);
        // R8/R9: every selector value in code 4
        for (int mx = 0; mx < 4; mx++)
            for (int b = 0; b < 2; b++)
                run_word(32'hF81F_07E0, 3'd4, b[0], 1'b0, 1'b0, 2'(mx), 1'b0);
        // R6: ignored bits set high
        run_word(32'hFF00_0000, 3'd5, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
        run_word(32'h8000_8000, 3'd4, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0);
        // random mix with config scrambled after accept (R12)
        for (int i = 0; i < 300; i++)
            run_word($urandom, 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     2'($urandom), 1'b1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule